// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models a 256-byte serial EEPROM that sits on a two-wire bus as a target. It runs on a fast system clock and samples the bus clock and data lines as ordinary inputs. It pulls the data line low through a single open-drain enable output and never drives it high. A bus controller selects the block with a device address byte. The upper nibble of that byte is a fixed family code, and the next three bits must match three strap inputs. The controller can then write single bytes or bursts, or read from a random or from the current address.

Written bytes go first into an 8-entry page buffer. A STOP starts a timed write cycle of a parameterised number of system clocks. When the cycle ends, the buffered bytes are copied into the array. During the cycle the block answers no device address, so the controller can poll until the write has finished. A write-protect input stops the array from changing. The address pointer keeps its value between transactions, which makes current-address reads possible.

Top module: `serial_eeprom_target`

## Requirements
- R1: A START is a falling data line and a STOP a rising data line, each while the clock line is high. A STOP at any point, even in the middle of a byte, releases the data line and returns the block to idle. A START at any point begins a new device-address byte.
- R2: The device address byte is sent MSB first. Bits 7:4 must be 1010 and bits 3:1 must equal strapAddr[2:0]; bit 0 is 1 for read and 0 for write. The block acknowledges an accepted byte by asserting sdaOe during the ninth clock.
- R3: After a device address that does not match, the block asserts sdaOe for nothing, including later bytes, until the next START.
- R4: In a write, the device address is followed by a word address and then data bytes, and the block acknowledges each of them. A single data byte closed by a STOP appears in the array after the write cycle.
- R5: Data bytes in a write go into an 8-byte page. Only address bits 2:0 advance, wrapping inside the page, and more than 8 bytes overwrite earlier ones. Only the bytes actually received are written, and the rest of the page keeps its contents.
- R6: Buffered data is committed only on a STOP. A repeated START after data bytes discards them and starts no write cycle.
- R7: From the STOP that closes a write until WRITE_CLKS system clocks have passed, the block does not acknowledge its device address. After that it does.
- R8: While wpIn is high at the STOP that closes a write, the array does not change and no write cycle starts.
- R9: A read shifts out the byte at the pointer MSB first. The pointer advances by one, wrapping from 255 to 0, after each byte the controller acknowledges. A controller NACK leaves sdaOe low and ends the transfer.
- R10: A word-address write followed by a repeated START and a read address reads from that word address. A read with no word address reads from the retained pointer.
- R11: After reset sdaOe is low, the pointer is 0 and every byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled bus clock line |
| sdaIn | input | 1 | Sampled bus data line (wired level) |
| strapAddr | input | 3 | Hard-wired device address bits |
| wpIn | input | 1 | Write protect, high blocks array changes |
| sdaOe | output | 1 | Open-drain enable, high pulls the data line low |

## Verification
The embedded properties check on every cycle that a STOP always frees the data line and that the block never pulls the line while idle. They also check that no acknowledge of the device address happens while the write timer runs, that page bursts never leave their page, and that a protected commit starts no timer. Only the bench scenarios can show the stored and returned byte values. The same holds for page wrap with overwrite and partial-page preservation, for the discard on a repeated START, for pointer wrap on sequential reads, and for the length of the busy window seen through acknowledge polling.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  localparam logic [3:0] DEV_FAMILY = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEVACK, S_WADDR, S_WADDRACK,
    S_WDATA, S_WDATAACK, S_RDATA, S_RACK
  } busState_t;

  // single-cycle strobes from bus control to the storage datapath
  typedef struct packed {
    logic       loadPtr;
    logic       pushByte;
    logic       incPtr;
    logic       commit;
    logic       discard;
    logic [7:0] rxByte;
  } dpCmd_t;

endpackage

// File: rtl/seeprom_ctrl.sv
module seeprom_ctrl
  import seeprom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  input  logic       busyIn,
  input  logic [7:0] rdByte,
  output logic       sdaOe,
  output dpCmd_t     cmd
);

  logic sclQ, sdaQ, sclP, sdaP;
  logic sclRise, sclFall, startSeen, stopSeen;
  busState_t state;
  logic [2:0] bitCnt;
  logic [7:0] shReg, txReg;
  logic byteDone, rnw, mAck, oeQ;
  dpCmd_t cmdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1; sdaQ <= 1'b1; sclP <= 1'b1; sdaP <= 1'b1;
    end else begin
      sclQ <= sclIn; sdaQ <= sdaIn; sclP <= sclQ; sdaP <= sdaQ;
    end
  end

  assign sclRise   = sclQ & ~sclP;
  assign sclFall   = ~sclQ & sclP;
  assign startSeen = sclQ & sclP & sdaP & ~sdaQ;
  assign stopSeen  = sclQ & sclP & ~sdaP & sdaQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      shReg    <= '0;
      txReg    <= '0;
      byteDone <= 1'b0;
      rnw      <= 1'b0;
      mAck     <= 1'b0;
      oeQ      <= 1'b0;
      cmdQ     <= '0;
    end else begin
      cmdQ.loadPtr  <= 1'b0;
      cmdQ.pushByte <= 1'b0;
      cmdQ.incPtr   <= 1'b0;
      cmdQ.commit   <= 1'b0;
      cmdQ.discard  <= 1'b0;
      if (startSeen) begin
        state        <= S_DEV;
        bitCnt       <= '0;
        byteDone     <= 1'b0;
        oeQ          <= 1'b0;
        cmdQ.discard <= 1'b1;
      end else if (stopSeen) begin
        state <= S_IDLE;
        oeQ   <= 1'b0;
        if (state == S_WDATA || state == S_WDATAACK) cmdQ.commit <= 1'b1;
        else cmdQ.discard <= 1'b1;
      end else begin
        case (state)
          S_DEV, S_WADDR, S_WDATA: begin
            if (sclRise) begin
              shReg  <= {shReg[6:0], sdaQ};
              bitCnt <= bitCnt + 3'd1;
              if (bitCnt == 3'd7) byteDone <= 1'b1;
            end else if (sclFall && byteDone) begin
              byteDone <= 1'b0;
              bitCnt   <= '0;
              if (state == S_DEV) begin
                if (shReg[7:1] == {DEV_FAMILY, strapAddr} && !busyIn) begin
                  oeQ   <= 1'b1;
                  rnw   <= shReg[0];
                  state <= S_DEVACK;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_WADDR) begin
                cmdQ.loadPtr <= 1'b1;
                cmdQ.rxByte  <= shReg;
                oeQ          <= 1'b1;
                state        <= S_WADDRACK;
              end else begin
                cmdQ.pushByte <= 1'b1;
                cmdQ.rxByte   <= shReg;
                oeQ           <= 1'b1;
                state         <= S_WDATAACK;
              end
            end
          end
          S_DEVACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (rnw) begin
                txReg <= rdByte;
                oeQ   <= ~rdByte[7];
                state <= S_RDATA;
              end else begin
                oeQ   <= 1'b0;
                state <= S_WADDR;
              end
            end
          end
          S_WADDRACK, S_WDATAACK: begin
            if (sclFall) begin
              oeQ   <= 1'b0;
              state <= S_WDATA;
            end
          end
          S_RDATA: begin
            if (sclFall) begin
              if (bitCnt == 3'd7) begin
                oeQ   <= 1'b0;
                state <= S_RACK;
              end else begin
                txReg  <= {txReg[6:0], 1'b0};
                oeQ    <= ~txReg[6];
                bitCnt <= bitCnt + 3'd1;
              end
            end
          end
          S_RACK: begin
            if (sclRise) begin
              mAck        <= ~sdaQ;
              cmdQ.incPtr <= ~sdaQ;
            end else if (sclFall) begin
              if (mAck) begin
                txReg  <= rdByte;
                oeQ    <= ~rdByte[7];
                bitCnt <= '0;
                state  <= S_RDATA;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: oeQ <= 1'b0;
        endcase
      end
    end
  end

  assign sdaOe = oeQ;
  assign cmd   = cmdQ;

  // R1: a STOP always leaves the line released on the next cycle
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe) else $error("stop did not release line");

  // R3: nothing is pulled while idle (mismatch or finished transfer)
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !sdaOe) else $error("line pulled while idle");

  // R7: device address acknowledge never overlaps the write timer
  p_no_ack_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DEVACK) |-> !busyIn) else $error("ack during write cycle");

endmodule

// File: rtl/seeprom_dp.sv
module seeprom_dp
  import seeprom_pkg::*;
#(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 8,
  parameter int WRITE_CLKS = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic       wpIn,
  output logic [7:0] rdByte,
  output logic       busy
);

  localparam int PTR_W = $clog2(MEM_BYTES);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int TMR_W = $clog2(WRITE_CLKS + 1);

  logic [7:0]       mem     [MEM_BYTES];
  logic [7:0]       pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageVld;
  logic [PTR_W-1:0] ptr;
  logic [TMR_W-1:0] timer;
  logic             busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
      pageVld <= '0;
      ptr     <= '0;
      timer   <= '0;
      busyQ   <= 1'b0;
    end else if (busyQ) begin
      if (timer == '0) begin
        busyQ <= 1'b0;
        for (int i = 0; i < PAGE_BYTES; i++)
          if (pageVld[i]) mem[{ptr[PTR_W-1:OFF_W], OFF_W'(i)}] <= pageBuf[i];
        pageVld <= '0;
      end else begin
        timer <= timer - 1'b1;
      end
    end else begin
      if (cmd.loadPtr) ptr <= cmd.rxByte[PTR_W-1:0];
      if (cmd.pushByte) begin
        pageBuf[ptr[OFF_W-1:0]] <= cmd.rxByte;
        pageVld[ptr[OFF_W-1:0]] <= 1'b1;
        ptr[OFF_W-1:0]          <= ptr[OFF_W-1:0] + 1'b1;
      end
      if (cmd.incPtr) ptr <= ptr + 1'b1;
      if (cmd.commit) begin
        if (|pageVld && !wpIn) begin
          busyQ <= 1'b1;
          timer <= TMR_W'(WRITE_CLKS - 1);
        end else begin
          pageVld <= '0;
        end
      end
      if (cmd.discard) pageVld <= '0;
    end
  end

  assign rdByte = mem[ptr];
  assign busy   = busyQ;

  // R5: a burst byte never moves the pointer off its page
  p_page_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.pushByte && !busyQ) |=> ptr[PTR_W-1:OFF_W] == $past(ptr[PTR_W-1:OFF_W]))
    else $error("page changed during burst");

  // R8: a protected commit never starts the write timer
  p_wp_no_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.commit && wpIn && !busyQ) |=> !busyQ) else $error("protected write started");

  // R7: no bus data reaches storage while the timer runs
  p_busy_no_push_r7: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> !(cmd.pushByte || cmd.loadPtr)) else $error("data accepted while busy");

endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
  import seeprom_pkg::*;
#(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 8,
  parameter int WRITE_CLKS = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  input  logic       wpIn,
  output logic       sdaOe
);

  dpCmd_t     cmd;
  logic [7:0] rdByte;
  logic       busy;

  seeprom_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .strapAddr (strapAddr),
    .busyIn    (busy),
    .rdByte    (rdByte),
    .sdaOe     (sdaOe),
    .cmd       (cmd)
  );

  seeprom_dp #(
    .MEM_BYTES  (MEM_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .WRITE_CLKS (WRITE_CLKS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .wpIn   (wpIn),
    .rdByte (rdByte),
    .busy   (busy)
  );

endmodule

// File: tb/test_serial_eeprom_target.sv
module test_serial_eeprom_target;

  localparam int WCLKS = 2000;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};
  // {word address, data}
  localparam logic [15:0] VEC [6] = '{16'h0012, 16'h0734, 16'h2A5A,
                                      16'h7FA5, 16'h8001, 16'hC8EE};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1, wpIn = 1'b0;
  logic sdaOe;
  wire  sdaLine = sdaDrv & ~sdaOe;
  logic [7:0] model [256];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_eeprom_target #(.WRITE_CLKS(WCLKS)) i_serial_eeprom_target (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .strapAddr(STRAP), .wpIn(wpIn), .sdaOe(sdaOe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ; repeat (4) @(negedge clk); endtask
  task automatic busStart;
    sdaDrv = 1; waitQ; sclDrv = 1; waitQ; sdaDrv = 0; waitQ; sclDrv = 0; waitQ;
  endtask
  task automatic busStop;
    sdaDrv = 0; waitQ; sclDrv = 1; waitQ; sdaDrv = 1; waitQ;
  endtask
  task automatic putBit(input logic b);
    sdaDrv = b; waitQ; sclDrv = 1; waitQ; sclDrv = 0; waitQ;
  endtask
  task automatic getBit(output logic b);
    sdaDrv = 1; waitQ; sclDrv = 1; waitQ; b = sdaLine; sclDrv = 0; waitQ;
  endtask
  task automatic sendByte(input logic [7:0] d, output logic ackd);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(d[i]);
    getBit(b);
    ackd = !b;
  endtask
  task automatic recvByte(output logic [7:0] d, input logic ackIt);
    logic b;
    for (int i = 0; i < 8; i++) begin getBit(b); d = {d[6:0], b}; end
    putBit(!ackIt);
  endtask

  // write n bytes base+k starting at a, closed by STOP; checks every acknowledge
  task automatic writeSeq(input logic [7:0] a, input int n, input logic [7:0] base);
    logic ack;
    busStart;
    sendByte(DEV_W, ack); check("R4 dev ack", ack, 1);
    sendByte(a, ack);     check("R4 word ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      sendByte(base + 8'(k), ack); check("R4 data ack", ack, 1);
    end
    busStop;
    if (!wpIn)
      for (int k = 0; k < n; k++)
        model[{a[7:3], 3'(a[2:0] + 3'(k))}] = base + 8'(k);
  endtask

  task automatic pollReady(output int polls);
    logic ack;
    polls = 0;
    do begin
      busStart; sendByte(DEV_W, ack); busStop; polls++;
    end while (!ack && polls < 200);
  endtask

  task automatic readCheck(input logic [7:0] a, input int n, input string req);
    logic ack;
    logic [7:0] d;
    busStart;
    sendByte(DEV_W, ack); sendByte(a, ack);
    busStart;
    sendByte(DEV_R, ack); check(req, ack, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(d, k != n - 1);
      check(req, d, model[8'(a + 8'(k))]);
    end
    check(req, sdaOe, 0);
    busStop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int polls;
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rstN = 1;
    waitQ;

    // R11: reset state and erased contents via a current-address read
    check("R11 oe after reset", sdaOe, 0);
    busStart;
    sendByte(DEV_R, ack); check("R2 read address ack", ack, 1);
    recvByte(d, 0); check("R11 erased byte", d, 8'hFF);
    busStop;

    // R4 / R7: table of byte writes, each polled then read back
    for (int v = 0; v < 6; v++) begin
      writeSeq(VEC[v][15:8], 1, VEC[v][7:0]);
      pollReady(polls);
      check("R7 first poll refused", int'(polls > 1), 1);
      readCheck(VEC[v][15:8], 1, "R4 readback");
    end

    // R7: busy window length is close to WCLKS
    writeSeq(8'h90, 1, 8'h77);
    pollReady(polls);
    check("R7 ready after timer", int'(polls > 3 && polls < 40), 1);

    // R3: wrong strap and wrong family are ignored, also for following bytes
    busStart;
    sendByte({4'b1010, 3'b001, 1'b0}, ack); check("R3 strap mismatch", ack, 0);
    sendByte(DEV_W, ack); check("R3 quiet until START", ack, 0);
    busStop;
    busStart;
    sendByte({4'b1011, STRAP, 1'b0}, ack); check("R3 family mismatch", ack, 0);
    busStop;

    // R5: ten bytes from offset 5 wrap inside page 0x18 and overwrite
    writeSeq(8'h1D, 10, 8'h40);
    pollReady(polls);
    readCheck(8'h18, 8, "R5 page wrap");
    // R5: partial page keeps neighbours
    writeSeq(8'h42, 2, 8'h90);
    pollReady(polls);
    readCheck(8'h40, 8, "R5 partial page");

    // R6: repeated START discards buffered data
    busStart;
    sendByte(DEV_W, ack); sendByte(8'h60, ack); sendByte(8'hAB, ack);
    busStart;
    sendByte(DEV_W, ack); check("R6 no write cycle", ack, 1);
    busStop;
    readCheck(8'h60, 1, "R6 discarded");

    // R8: write protect
    wpIn = 1;
    writeSeq(8'h30, 1, 8'h55);
    busStart; sendByte(DEV_W, ack); check("R8 no timer", ack, 1); busStop;
    wpIn = 0;
    readCheck(8'h30, 1, "R8 array unchanged");

    // R9: sequential read wraps 255 -> 0
    writeSeq(8'hFF, 1, 8'h3C); pollReady(polls);
    writeSeq(8'h00, 1, 8'hC3); pollReady(polls);
    readCheck(8'hFF, 2, "R9 wrap read");

    // R10: current-address read uses retained pointer (0 after NACK on byte 0)
    busStart;
    sendByte(DEV_R, ack); check("R10 ack", ack, 1);
    recvByte(d, 0); check("R10 current address", d, model[0]);
    busStop;
    readCheck(8'h42, 1, "R10 random read");

    // R1: STOP mid-byte, START mid-byte
    busStart; putBit(1); putBit(0); putBit(1);
    busStop;
    check("R1 released after stop", sdaOe, 0);
    busStart; putBit(1); putBit(0); putBit(1);
    busStart;
    sendByte(DEV_W, ack); check("R1 restart accepted", ack, 1);
    busStop;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule